// File: doc/BRIEF.md
# UART register-bank access bridge

The bridge lets a host on a serial line set and read a bank of 32-bit user registers. Bytes arrive 8N1, least significant bit first. The receive line is oversampled sixteen times per bit, and one bit lasts 16*TICK_DIV clock cycles. Six consecutive bytes make one command: a 16-bit address and then a 32-bit data word, with the most significant byte first in both fields. A command to an address below NREG goes into a staging copy of that register. The control outputs do not change at this point.

A command to address 0x8000 with data zero is the update command. In one clock cycle it copies every staged value to the control outputs and captures every status input into a snapshot. The bridge then sends the snapshot back to the host. It sends one six-byte frame per register, in ascending address order, and each frame uses the same layout as a command. Two recovery rules keep the byte stream aligned. A partial command that stalls is dropped after a timeout. A byte that ends with a low stop bit restarts command assembly.

The serial format is applied from reset, so the host needs no setup sequence.

Top module: `uart_regbank_bridge`

## Requirements
- R1: After reset, every control output is zero and txd idles high.
- R2: A six-byte command to an address below NREG changes only that register's staged value. The control outputs keep their value until an update command.
- R3: A command to an address of NREG or above is discarded, unless it is the update command. No staged value changes.
- R4: A command with address 0x8000 and data 0x00000000 copies all staged values to ctrl_out (register i on bits 32*i+31..32*i) in one cycle. The command itself is not stored in any register.
- R5: A command to address 0x8000 with nonzero data has no effect. No outputs change and no readback is sent.
- R6: The update captures status_in in the same cycle as the commit. Later changes of status_in do not alter the frames being returned.
- R7: After an update, txd carries NREG frames for addresses 0 to NREG-1 in order. Each frame is two address bytes, then four snapshot data bytes, most significant byte first, each byte 8N1 with the LSB first.
- R8: If a partial command sees no new byte for TO_CHARS*160 oversample ticks, it is discarded. The next byte is taken as an address high byte.
- R9: A byte whose stop bit is sampled low is dropped and command assembly restarts. No register changes.
- R10: An update command that arrives while a readback is in progress is ignored, with no commit and no new readback. Ordinary commands are still staged during a readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial data from host |
| txd | output | 1 | Serial data to host |
| ctrl_out | output | NREG*32 | Committed control registers |
| status_in | input | NREG*32 | User status to be captured |

## Verification
The commit takes place one cycle after the centre of the sixth byte's stop bit. The bench checks ctrl_out once its own full stop bit has ended, about 16 cycles later, so the value has settled by then. The readback start bit follows the update within one oversample tick. For this reason a concurrent receiver in the bench arms on the first falling edge of txd and samples each bit at its centre, every 32 cycles. The timeout checks wait 1600 cycles, which is longer than the 1280-cycle limit. Normal byte gaps in the bench stay well inside that limit.

// File: rtl/uart_regbank_bridge.sv
module uart_regbank_bridge #(
  parameter int NREG = 4,
  parameter int TICK_DIV = 2,
  parameter int TO_CHARS = 4,
  parameter logic [15:0] UPD_ADDR = 16'h8000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  output logic                 txd,
  output logic [NREG*32-1:0]   ctrl_out,
  input  logic [NREG*32-1:0]   status_in
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TO_TICKS = TO_CHARS * 160;
  localparam int TW = $clog2(TO_TICKS + 1);

  logic [DW-1:0] div_q;
  logic [1:0] rx_sync;
  logic rx_prev, rx_busy, rx_done, rx_ferr;
  logic [3:0] rx_cnt, rx_bit;
  logic [7:0] rx_sh;
  logic [2:0] fr_cnt;
  logic [39:0] fr_buf;
  logic [TW-1:0] to_cnt;
  logic [31:0] shadow [NREG];
  logic [31:0] snap [NREG];
  logic tx_busy;
  logic [IW-1:0] tx_reg;
  logic [2:0] tx_byte;
  logic [3:0] tx_bit, tx_cnt;
  logic [7:0] tx_cur;
  logic tx_val;

  wire tick = (div_q == DW'(TICK_DIV - 1));
  wire rx_in = rx_sync[1];
  wire [47:0] frame = {fr_buf, rx_sh};
  wire fr_last = rx_done && (fr_cnt == 3'd5);
  wire [15:0] f_addr = frame[47:32];
  wire [31:0] f_data = frame[31:0];
  wire upd = fr_last && (f_addr == UPD_ADDR) && (f_data == 32'd0) && !tx_busy;
  wire wr = fr_last && (f_addr < 16'(NREG));
  wire to_hit = tick && (fr_cnt != 3'd0) && (to_cnt == TW'(TO_TICKS - 1));
  wire [47:0] tx_word = {16'(tx_reg), snap[tx_reg]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else div_q <= tick ? '0 : div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11; rx_prev <= 1'b1; rx_busy <= 1'b0;
      rx_cnt <= '0; rx_bit <= '0; rx_sh <= '0;
      rx_done <= 1'b0; rx_ferr <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      rx_done <= 1'b0;
      rx_ferr <= 1'b0;
      if (tick) begin
        rx_prev <= rx_in;
        if (!rx_busy) begin
          if (rx_prev && !rx_in) begin
            rx_busy <= 1'b1; rx_cnt <= '0; rx_bit <= '0;
          end
        end else if (rx_bit == 4'd0) begin
          if (rx_cnt == 4'd7) begin
            if (rx_in) rx_busy <= 1'b0;
            else begin rx_cnt <= '0; rx_bit <= 4'd1; end
          end else rx_cnt <= rx_cnt + 1'b1;
        end else if (rx_cnt == 4'd15) begin
          rx_cnt <= '0;
          if (rx_bit == 4'd9) begin
            rx_busy <= 1'b0; rx_done <= rx_in; rx_ferr <= !rx_in;
          end else begin
            rx_sh <= {rx_in, rx_sh[7:1]}; rx_bit <= rx_bit + 1'b1;
          end
        end else rx_cnt <= rx_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_cnt <= '0; fr_buf <= '0; to_cnt <= '0;
    end else if (rx_ferr || to_hit) begin
      fr_cnt <= '0; to_cnt <= '0;
    end else if (rx_done) begin
      fr_buf <= {fr_buf[31:0], rx_sh};
      fr_cnt <= fr_last ? 3'd0 : fr_cnt + 1'b1;
      to_cnt <= '0;
    end else if (tick && fr_cnt != 3'd0) begin
      to_cnt <= to_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_out <= '0;
      for (int i = 0; i < NREG; i++) begin shadow[i] <= '0; snap[i] <= '0; end
    end else begin
      if (wr) shadow[f_addr[IW-1:0]] <= f_data;
      if (upd)
        for (int i = 0; i < NREG; i++) begin
          ctrl_out[i*32 +: 32] <= shadow[i];
          snap[i] <= status_in[i*32 +: 32];
        end
    end
  end

  always_comb begin
    tx_cur = tx_word[8*(3'd5 - tx_byte) +: 8];
    if (tx_bit == 4'd0) tx_val = 1'b0;
    else if (tx_bit == 4'd9) tx_val = 1'b1;
    else tx_val = tx_cur[3'(tx_bit - 4'd1)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd <= 1'b1; tx_busy <= 1'b0; tx_reg <= '0;
      tx_byte <= '0; tx_bit <= '0; tx_cnt <= '0;
    end else begin
      txd <= tx_busy ? tx_val : 1'b1;
      if (upd) begin
        tx_busy <= 1'b1; tx_reg <= '0; tx_byte <= '0; tx_bit <= '0; tx_cnt <= '0;
      end else if (tx_busy && tick) begin
        if (tx_cnt == 4'd15) begin
          tx_cnt <= '0;
          if (tx_bit == 4'd9) begin
            tx_bit <= '0;
            if (tx_byte == 3'd5) begin
              tx_byte <= '0;
              if (tx_reg == IW'(NREG - 1)) tx_busy <= 1'b0;
              else tx_reg <= tx_reg + 1'b1;
            end else tx_byte <= tx_byte + 1'b1;
          end else tx_bit <= tx_bit + 1'b1;
        end else tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  logic [NREG*32-1:0] snap_flat;
  always_comb
    for (int i = 0; i < NREG; i++) snap_flat[i*32 +: 32] = snap[i];
endmodule

// File: rtl/uart_regbank_bridge_chk.sv
module uart_regbank_bridge_chk #(
  parameter int NREG = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd,
  input logic               tx_busy,
  input logic               rx_ferr,
  input logic [2:0]         fr_cnt,
  input logic               txd,
  input logic [NREG*32-1:0] ctrl_out,
  input logic [NREG*32-1:0] snap_flat
);
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !$past(tx_busy)) |-> txd); // R1
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_cnt <= 3'd5); // R2
  AST_CTRL_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd) |-> $stable(ctrl_out)); // R4
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(snap_flat)); // R6
  AST_READBACK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> tx_busy); // R7
  AST_FERR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |=> (fr_cnt == 3'd0)); // R9
endmodule

bind uart_regbank_bridge uart_regbank_bridge_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .tx_busy(tx_busy), .rx_ferr(rx_ferr),
  .fr_cnt(fr_cnt), .txd(txd), .ctrl_out(ctrl_out), .snap_flat(snap_flat)
);

// File: tb/uart_regbank_bridge_tb.sv
`timescale 1ns/1ps
module uart_regbank_bridge_tb;
  localparam int NREG = 4;
  localparam int BITC = 32;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic txd;
  logic [NREG*32-1:0] ctrl_out, status_in;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] shadow_m [NREG];
  logic [31:0] ctrl_m [NREG];
  logic [31:0] snap_m [NREG];

  always #4 clk = ~clk;

  uart_regbank_bridge #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
    .ctrl_out(ctrl_out), .status_in(status_in));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    rxd = 1'b0; wait_clks(BITC);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_clks(BITC); end
    rxd = stop_ok; wait_clks(BITC);
    rxd = 1'b1;
    if (!stop_ok) wait_clks(BITC);
  endtask

  task automatic send_frame(input logic [15:0] a, input logic [31:0] d);
    logic [47:0] w;
    w = {a, d};
    for (int k = 0; k < 6; k++) send_byte(w[47-8*k -: 8], 1'b1);
  endtask

  function automatic void model_cmd(input logic [15:0] a, input logic [31:0] d);
    if (a < 16'(NREG)) shadow_m[a[1:0]] = d;
  endfunction

  task automatic recv_byte(output logic [7:0] b);
    @(negedge txd);
    wait_clks(BITC/2);
    for (int i = 0; i < 8; i++) begin wait_clks(BITC); b[i] = txd; end
    wait_clks(BITC);
    chk("R7 stop bit", {31'd0, txd}, 32'd1);
  endtask

  task automatic collect();
    logic [7:0] b;
    logic [47:0] w;
    for (int r = 0; r < NREG; r++) begin
      w = {16'(r), snap_m[r]};
      for (int k = 0; k < 6; k++) begin
        recv_byte(b);
        chk($sformatf("R7 R6 readback reg %0d byte %0d", r, k), {24'd0, b}, {24'd0, w[47-8*k -: 8]});
      end
    end
  endtask

  task automatic check_ctrl(input string req);
    for (int i = 0; i < NREG; i++)
      chk($sformatf("%s ctrl_out reg %0d", req, i), ctrl_out[i*32 +: 32], ctrl_m[i]);
  endtask

  task automatic check_quiet(input string req, input int n);
    logic seen_low;
    seen_low = 1'b0;
    for (int i = 0; i < n; i++) begin wait_clks(1); if (!txd) seen_low = 1'b1; end
    chk({req, " txd stays idle"}, {31'd0, seen_low}, 32'd0);
  endtask

  task automatic do_update(input string req);
    for (int i = 0; i < NREG; i++) begin
      snap_m[i] = status_in[i*32 +: 32];
      ctrl_m[i] = shadow_m[i];
    end
    fork
      begin
        send_frame(16'h8000, 32'd0);
        wait_clks(4);
        check_ctrl(req);
        status_in = {$urandom, $urandom, $urandom, $urandom};
      end
      collect();
    join
    wait_clks(BITC);
  endtask

  initial begin
    #(8ns * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [31:0] d;
    void'($urandom(32'd1234));
    status_in = {32'hA0A0_0003, 32'h1234_0002, 32'hDEAD_BEEF, 32'h0101_0100};
    for (int i = 0; i < NREG; i++) begin shadow_m[i] = '0; ctrl_m[i] = '0; snap_m[i] = '0; end
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(5);
    check_ctrl("R1 reset");
    chk("R1 txd idle", {31'd0, txd}, 32'd1);

    for (int i = 0; i < NREG; i++) begin
      d = 32'h1100_0000 * (i + 1) + 32'h55;
      send_frame(16'(i), d); model_cmd(16'(i), d);
    end
    wait_clks(4);
    check_ctrl("R2 staged only");

    send_frame(16'h0004, 32'hBAD0_0004);
    send_frame(16'h1234, 32'hBAD0_1234);
    wait_clks(4);
    check_ctrl("R3 out of range");
    send_frame(16'h8000, 32'h0000_0005);
    check_quiet("R5 nonzero update data", 600);
    check_ctrl("R5 nonzero update data");

    do_update("R4 R3 commit");

    send_byte(8'h00, 1'b1); send_byte(8'h02, 1'b1); send_byte(8'h77, 1'b1);
    wait_clks(1600);
    send_frame(16'h0001, 32'hCAFE_0001); model_cmd(16'h0001, 32'hCAFE_0001);
    do_update("R8 timeout");

    send_byte(8'h00, 1'b1); send_byte(8'h03, 1'b1); send_byte(8'h44, 1'b0);
    send_frame(16'h0003, 32'h0BAD_F00D); model_cmd(16'h0003, 32'h0BAD_F00D);
    do_update("R9 framing");

    for (int i = 0; i < NREG; i++) begin
      snap_m[i] = status_in[i*32 +: 32];
      ctrl_m[i] = shadow_m[i];
    end
    fork
      begin
        send_frame(16'h8000, 32'd0);
        send_frame(16'h0000, 32'h5EED_0000);
        send_frame(16'h8000, 32'd0);
      end
      collect();
    join
    model_cmd(16'h0000, 32'h5EED_0000);
    wait_clks(4);
    check_ctrl("R10 update while busy");
    check_quiet("R10 no second readback", 800);
    do_update("R10 staged during readback");

    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 3; k++) begin
        a = 16'($urandom_range(0, 7));
        d = $urandom;
        send_frame(a, d); model_cmd(a, d);
      end
      do_update($sformatf("R2 R4 random round %0d", r));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule